// File: doc/BRIEF.md
# Mixed-Width Shared Word/Nibble RAM

This block is a dual-port synchronous memory. Both ports reach one shared store of 32-bit words. A host on the bus side sees the store as whole words and reaches them by byte address. Fabric logic sees the same bits as one flat array of 4-bit values and reaches each value by a linear location number. A value written through either port can be read back through the other, so a word loaded by the host can be consumed one nibble at a time, and the reverse.

Inside each word the eight nibbles are packed with the most significant field first. Location 8N sits in the top four bits of word N and location 8N+7 in the bottom four. Both ports run on one clock. Each port has its own enable, write enable, address, write data and read data. The read data comes from a register, and a parameter on each port adds a second output register to relieve the clock-to-out path of the storage array.

Top module: `nibble_dpram`

## Requirements
- R1: The store holds 2^WORD_IDX_W words of 32 bits, each packing eight nibbles. The word-port byte address is WORD_IDX_W+2 bits wide and the nibble-port location is WORD_IDX_W+3 bits wide, so the last word and the last location are both reachable.
- R2: The word port selects word index byteAddrA >> 2. Bits [1:0] of byteAddrA have no effect on reads or writes.
- R3: Nibble location L maps to word L >> 3, lane L[2:0]. Lane k occupies bits [31-4k : 28-4k], so lane 0 is bits [31:28] and lane 7 is bits [3:0].
- R4: A nibble write changes only its own 4-bit field. The other seven nibbles of the word keep their values.
- R5: Each port reads first. A read and a write on the same port to the same address in one cycle return the data held before the write.
- R6: Read latency is one clock when the port's pipeline parameter is 0 and two clocks when it is 1.
- R7: While a port's enable is low that port neither reads nor writes, even with its write enable high, and its read data holds its value.
- R8: Synchronous reset clears every read-data register of both ports to zero and leaves the stored words unchanged.
- R9: Writes from both ports in the same cycle to different words both take effect. Writes from both ports to the same word in one cycle leave that word undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset of the read-data registers |
| enA | input | 1 | Word port enable |
| weA | input | 1 | Word port write enable |
| byteAddrA | input | WORD_IDX_W+2 | Word port byte address |
| wdataA | input | 32 | Word port write data |
| rdataA | output | 32 | Word port read data |
| enB | input | 1 | Nibble port enable |
| weB | input | 1 | Nibble port write enable |
| nibAddrB | input | WORD_IDX_W+3 | Nibble port linear location |
| wdataB | input | 4 | Nibble port write data |
| rdataB | output | 4 | Nibble port read data |

## Verification
The bench builds two copies of the block with WORD_IDX_W = 10, which gives 1024 words, so the last word and location 8191 can both be reached. One copy has both pipeline parameters at 0 and the other has both at 1. The two copies get the same stimulus and hold the same contents. Every read therefore checks the one-clock path and the two-clock path together, and a back-to-back read shows the pipelined copy still presenting the older value one clock after the read.

// File: rtl/nibble_dpram_pkg.sv
package nibble_dpram_pkg;
  localparam int WORD_W    = 32;
  localparam int NIB_W     = 4;
  localparam int NUM_LANES = WORD_W / NIB_W;
  localparam int LANE_W    = $clog2(NUM_LANES);
  localparam int SHIFT_W   = $clog2(WORD_W);
  localparam int BYTE_SEL_W = $clog2(WORD_W / 8);

  typedef struct packed {
    logic wrA;
    logic rdA;
    logic wrB;
    logic rdB;
  } ramStrobe_t;
endpackage

// File: rtl/nibble_dpram_ctrl.sv
module nibble_dpram_ctrl
  import nibble_dpram_pkg::*;
#(
  parameter int WORD_IDX_W = 10
) (
  input  logic                               enA,
  input  logic                               weA,
  input  logic [WORD_IDX_W+BYTE_SEL_W-1:0]   byteAddrA,
  input  logic                               enB,
  input  logic                               weB,
  input  logic [WORD_IDX_W+LANE_W-1:0]       nibAddrB,
  output ramStrobe_t                         strobe,
  output logic [WORD_IDX_W-1:0]              wordA,
  output logic [WORD_IDX_W-1:0]              wordB,
  output logic [LANE_W-1:0]                  laneB
);
  logic unusedByteSel;

  // The word port addresses bytes; the lane bits inside a word are dropped.
  assign wordA         = byteAddrA[WORD_IDX_W+BYTE_SEL_W-1:BYTE_SEL_W];
  assign unusedByteSel = ^byteAddrA[BYTE_SEL_W-1:0];

  // Linear nibble location: upper bits pick the word, low bits the lane.
  assign wordB = nibAddrB[WORD_IDX_W+LANE_W-1:LANE_W];
  assign laneB = nibAddrB[LANE_W-1:0];

  always_comb begin
    strobe.rdA = enA;
    strobe.wrA = enA & weA;
    strobe.rdB = enB;
    strobe.wrB = enB & weB;
  end
endmodule

// File: rtl/nibble_dpram_core.sv
module nibble_dpram_core
  import nibble_dpram_pkg::*;
#(
  parameter int WORD_IDX_W = 10,
  parameter bit PIPE_A     = 1'b0,
  parameter bit PIPE_B     = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ramStrobe_t            strobe,
  input  logic [WORD_IDX_W-1:0] wordA,
  input  logic [WORD_W-1:0]     wdataA,
  input  logic [WORD_IDX_W-1:0] wordB,
  input  logic [LANE_W-1:0]     laneB,
  input  logic [NIB_W-1:0]      wdataB,
  output logic [WORD_W-1:0]     rdataA,
  output logic [NIB_W-1:0]      rdataB
);
  localparam int NUM_WORDS = 1 << WORD_IDX_W;

  logic [WORD_W-1:0]  mem [NUM_WORDS];
  logic [WORD_W-1:0]  stgA;
  logic [NIB_W-1:0]   stgB;
  logic [SHIFT_W-1:0] shiftB;
  logic [WORD_W-1:0]  keepMaskB;
  logic               sameWordWr;

  // Lane 0 is the most significant field of the word.
  assign shiftB     = SHIFT_W'((NUM_LANES - 1 - int'(laneB)) * NIB_W);
  assign keepMaskB  = ~(WORD_W'({NIB_W{1'b1}}) << shiftB);
  assign sameWordWr = strobe.wrA && strobe.wrB && (wordA == wordB);

  // Single writer process; a same-word clash leaves the word undefined.
  always_ff @(posedge clk) begin
    if (strobe.wrA) mem[wordA] <= wdataA;
    if (strobe.wrB) mem[wordB][shiftB +: NIB_W] <= wdataB;
  end

  // First read stage, read-first against the write above.
  always_ff @(posedge clk) begin
    if (rst) begin
      stgA <= '0;
      stgB <= '0;
    end else begin
      if (strobe.rdA) stgA <= mem[wordA];
      if (strobe.rdB) stgB <= NIB_W'(mem[wordB] >> shiftB);
    end
  end

  generate
    if (PIPE_A) begin : gPipeA
      logic [WORD_W-1:0] outA;
      always_ff @(posedge clk) begin
        if (rst) outA <= '0;
        else     outA <= stgA;
      end
      assign rdataA = outA;
    end else begin : gDirectA
      assign rdataA = stgA;
    end

    if (PIPE_B) begin : gPipeB
      logic [NIB_W-1:0] outB;
      always_ff @(posedge clk) begin
        if (rst) outB <= '0;
        else     outB <= stgB;
      end
      assign rdataB = outB;
    end else begin : gDirectB
      assign rdataB = stgB;
    end
  endgenerate

  // R2
  word_write_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrA && !sameWordWr) |=> mem[$past(wordA)] == $past(wdataA));

  // R4
  nibble_field_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrB && !sameWordWr) |=>
      NIB_W'(mem[$past(wordB)] >> $past(shiftB)) == $past(wdataB));

  // R4
  nibble_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrB && !sameWordWr) |=>
      (mem[$past(wordB)] & $past(keepMaskB)) == ($past(mem[wordB]) & $past(keepMaskB)));

  // R5
  read_first_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.rdA |=> stgA == $past(mem[wordA]));

  // R7
  hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.rdA |=> $stable(stgA));

  // R7
  hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.rdB |=> $stable(stgB));
endmodule

// File: rtl/nibble_dpram.sv
module nibble_dpram
  import nibble_dpram_pkg::*;
#(
  parameter int WORD_IDX_W = 10,
  parameter bit PIPE_A     = 1'b0,
  parameter bit PIPE_B     = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enA,
  input  logic                    weA,
  input  logic [WORD_IDX_W+1:0]   byteAddrA,
  input  logic [31:0]             wdataA,
  output logic [31:0]             rdataA,
  input  logic                    enB,
  input  logic                    weB,
  input  logic [WORD_IDX_W+2:0]   nibAddrB,
  input  logic [3:0]              wdataB,
  output logic [3:0]              rdataB
);
  ramStrobe_t            strobe;
  logic [WORD_IDX_W-1:0] wordA;
  logic [WORD_IDX_W-1:0] wordB;
  logic [LANE_W-1:0]     laneB;

  nibble_dpram_ctrl #(.WORD_IDX_W(WORD_IDX_W)) ctrl_i (
    .enA(enA), .weA(weA), .byteAddrA(byteAddrA),
    .enB(enB), .weB(weB), .nibAddrB(nibAddrB),
    .strobe(strobe), .wordA(wordA), .wordB(wordB), .laneB(laneB)
  );

  nibble_dpram_core #(
    .WORD_IDX_W(WORD_IDX_W), .PIPE_A(PIPE_A), .PIPE_B(PIPE_B)
  ) core_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .wordA(wordA), .wdataA(wdataA),
    .wordB(wordB), .laneB(laneB), .wdataB(wdataB),
    .rdataA(rdataA), .rdataB(rdataB)
  );
endmodule

// File: tb/nibble_dpram_tb_top.sv
module nibble_dpram_tb_top;
  localparam int IDX_W = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              enA = 1'b0, weA = 1'b0, enB = 1'b0, weB = 1'b0;
  logic [IDX_W+1:0]  byteAddrA = '0;
  logic [IDX_W+2:0]  nibAddrB = '0;
  logic [31:0]       wdataA = '0;
  logic [3:0]        wdataB = '0;
  logic [31:0]       rA0, rA1;
  logic [3:0]        rB0, rB1;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nibble_dpram #(.WORD_IDX_W(IDX_W), .PIPE_A(1'b0), .PIPE_B(1'b0)) dut_i (
    .clk(clk), .rst(rst), .enA(enA), .weA(weA), .byteAddrA(byteAddrA),
    .wdataA(wdataA), .rdataA(rA0), .enB(enB), .weB(weB),
    .nibAddrB(nibAddrB), .wdataB(wdataB), .rdataB(rB0)
  );

  nibble_dpram #(.WORD_IDX_W(IDX_W), .PIPE_A(1'b1), .PIPE_B(1'b1)) dutPipe_i (
    .clk(clk), .rst(rst), .enA(enA), .weA(weA), .byteAddrA(byteAddrA),
    .wdataA(wdataA), .rdataA(rA1), .enB(enB), .weB(weB),
    .nibAddrB(nibAddrB), .wdataB(wdataB), .rdataB(rB1)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeA(int addr, logic [31:0] d);
    @(negedge clk);
    enA = 1'b1; weA = 1'b1; byteAddrA = (IDX_W+2)'(addr); wdataA = d;
    @(negedge clk);
    enA = 1'b0; weA = 1'b0;
  endtask

  task automatic writeB(int loc, logic [3:0] d);
    @(negedge clk);
    enB = 1'b1; weB = 1'b1; nibAddrB = (IDX_W+3)'(loc); wdataB = d;
    @(negedge clk);
    enB = 1'b0; weB = 1'b0;
  endtask

  // Direct copy valid one clock after the read, pipelined copy after two (R6).
  task automatic readA(int addr, logic [31:0] exp, string tag);
    @(negedge clk);
    enA = 1'b1; byteAddrA = (IDX_W+2)'(addr);
    @(negedge clk);
    enA = 1'b0;
    check({tag, " direct"}, rA0, exp);
    @(negedge clk);
    check({tag, " R6 pipelined"}, rA1, exp);
  endtask

  task automatic readB(int loc, logic [3:0] exp, string tag);
    @(negedge clk);
    enB = 1'b1; nibAddrB = (IDX_W+3)'(loc);
    @(negedge clk);
    enB = 1'b0;
    check({tag, " direct"}, 32'(rB0), 32'(exp));
    @(negedge clk);
    check({tag, " R6 pipelined"}, 32'(rB1), 32'(exp));
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R8 reset rdataA", rA0, 32'h0);
    check("R8 reset rdataB", 32'(rB0), 32'h0);
    check("R8 reset rdataA pipe", rA1, 32'h0);
    check("R8 reset rdataB pipe", 32'(rB1), 32'h0);
    rst = 1'b0;
  endtask

  task automatic testWordToNibble();
    writeA(32, 32'h12345678);
    for (int k = 0; k < 8; k++)
      readB(64 + k, 4'(k + 1), "R3 word8 lane");
    writeA(0, 32'hA0000005);
    readB(0, 4'hA, "R3 loc0 top field");
    readB(7, 4'h5, "R3 loc7 bottom field");
  endtask

  task automatic testByteLowBits();
    writeA(36 | 3, 32'hCAFEF00D);
    readA(36, 32'hCAFEF00D, "R2 low bits on write");
    readA(37, 32'hCAFEF00D, "R2 low bits on read");
    readA(32 | 2, 32'h12345678, "R2 word8 via byte34");
  endtask

  task automatic testNibbleToWord();
    writeA(80, 32'h0);
    for (int k = 0; k < 8; k++)
      writeB(160 + k, 4'(9 + k));
    readA(80, 32'h9ABCDEF0, "R3 nibbles packed into word20");
  endtask

  task automatic testNibbleKeep();
    writeA(88, 32'hFFFFFFFF);
    writeB(22 * 8 + 5, 4'h0);
    readA(88, 32'hFFFFF0FF, "R4 lane5 cleared only");
  endtask

  task automatic testReadFirst();
    @(negedge clk);
    enA = 1'b1; weA = 1'b1; byteAddrA = (IDX_W+2)'(32); wdataA = 32'hA5A5A5A5;
    @(negedge clk);
    enA = 1'b0; weA = 1'b0;
    check("R5 port A old data", rA0, 32'h12345678);
    readA(32, 32'hA5A5A5A5, "R5 port A new data");
    @(negedge clk);
    enB = 1'b1; weB = 1'b1; nibAddrB = (IDX_W+3)'(64); wdataB = 4'h3;
    @(negedge clk);
    enB = 1'b0; weB = 1'b0;
    check("R5 port B old data", 32'(rB0), 32'hA);
    readB(64, 4'h3, "R5 port B new data");
  endtask

  task automatic testLatency();
    readA(80, 32'h9ABCDEF0, "R6 first read");
    @(negedge clk);
    enA = 1'b1; byteAddrA = (IDX_W+2)'(88);
    @(negedge clk);
    enA = 1'b0;
    check("R6 direct after one clock", rA0, 32'hFFFFF0FF);
    check("R6 pipelined still old", rA1, 32'h9ABCDEF0);
    @(negedge clk);
    check("R6 pipelined after two clocks", rA1, 32'hFFFFF0FF);
  endtask

  task automatic testEnableLow();
    @(negedge clk);
    enA = 1'b0; weA = 1'b1; byteAddrA = (IDX_W+2)'(32); wdataA = 32'h0;
    enB = 1'b0; weB = 1'b1; nibAddrB = (IDX_W+3)'(65); wdataB = 4'hE;
    @(negedge clk);
    @(negedge clk);
    weA = 1'b0; weB = 1'b0;
    check("R7 rdataA holds", rA1, 32'hFFFFF0FF);
    check("R7 rdataB holds", 32'(rB1), 32'h3);
    readA(32, 32'h35A5A5A5, "R7 word write ignored");
    readB(65, 4'h5, "R7 nibble write ignored");
  endtask

  task automatic testDualWrite();
    writeA(124, 32'h0);
    @(negedge clk);
    enA = 1'b1; weA = 1'b1; byteAddrA = (IDX_W+2)'(120); wdataA = 32'h11111111;
    enB = 1'b1; weB = 1'b1; nibAddrB = (IDX_W+3)'(248); wdataB = 4'h7;
    @(negedge clk);
    enA = 1'b0; weA = 1'b0; enB = 1'b0; weB = 1'b0;
    readA(120, 32'h11111111, "R9 port A write kept");
    readA(124, 32'h70000000, "R9 port B write kept");
  endtask

  task automatic testTopBoundary();
    writeA(4092, 32'h0F1E2D3C);
    readB(8191, 4'hC, "R1 last location");
    readB(8184, 4'h0, "R1 first lane of last word");
    readA(4095, 32'h0F1E2D3C, "R1 last word");
  endtask

  task automatic testResetKeepsData();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 mid-run clear A", rA0, 32'h0);
    check("R8 mid-run clear A pipe", rA1, 32'h0);
    check("R8 mid-run clear B pipe", 32'(rB1), 32'h0);
    readA(4092, 32'h0F1E2D3C, "R8 contents kept");
  endtask

  initial begin
    testReset();
    testWordToNibble();
    testByteLowBits();
    testNibbleToWord();
    testNibbleKeep();
    testReadFirst();
    testLatency();
    testEnableLow();
    testDualWrite();
    testTopBoundary();
    testResetKeepsData();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule